// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a two-level logic array that can be configured while it runs. A few input signals feed a bank of product terms, the AND plane. Each term is the AND of the literals it selects. A second bank of connections, the OR plane, attaches each term to any set of outputs, so one term can be shared by several functions. Each output is the OR of the terms connected to it. Evaluation is purely combinational, so outputs follow the inputs within the same cycle.

Configuration words are written through a synchronous port. Software raises a load window, writes words one at a time (term index, plane select, data), and then drops the window. For as long as the window is open, every output is held at 0, so no half-written function is ever visible.

A mode input switches the OR plane into a fixed-bank mode. In that mode, each output can reach only its own group of consecutive terms, and any connection bits outside that group are ignored.

Top module: `sop_array`

## Requirements
- R1: After reset, every AND-plane literal is don't-care, every OR-plane connection is clear, and all outputs read 0.
- R2: The AND word of a term holds, for input i, the 2-bit field at bits [2i+1:2i] coded {needTrue, needFalse}. 10 requires input i to be 1, 01 requires it to be 0, 00 is don't-care, and 11 makes the whole term constant false.
- R3: A term whose literals are all don't-care evaluates to 1.
- R4: An output with no connected terms evaluates to 0.
- R5: Bit o of a term's OR word connects that term to output o. A term may drive several outputs, and each output is the OR of its connected terms.
- R6: While cfgLoad is 1, a one-cycle cfgWrEn stores cfgData into term cfgTerm at the next rising edge. With cfgPlane=0 the low 2*NUM_IN bits go to the AND plane; with cfgPlane=1 the low NUM_OUT bits go to the OR plane.
- R7: A cfgWrEn pulse while cfgLoad is 0 leaves the configuration unchanged.
- R8: While cfgLoad is 1, all outputs are 0.
- R9: With palMode=1, output o reaches only terms o*PAL_BANK to o*PAL_BANK+PAL_BANK-1, and connection bits outside that range are ignored. With palMode=0, every term can reach every output.
- R10: With 3 inputs (inVec[0]=A, inVec[1]=B, inVec[2]=C) and 5 shared terms, the array realises F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A.
- R11: Once configured, outputs follow a change on inVec with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| palMode | input | 1 | 1 selects fixed per-output term banks |
| cfgLoad | input | 1 | Configuration window; blanks the outputs |
| cfgWrEn | input | 1 | One-cycle write strobe |
| cfgPlane | input | 1 | 0 selects the AND plane, 1 selects the OR plane |
| cfgTerm | input | TERM_W | Term index for the write |
| cfgData | input | DATA_W | Configuration word |
| inVec | input | NUM_IN | Logic inputs |
| funcOut | output | NUM_OUT | Sum-of-products outputs |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- outputs are blanked during the load window;
- a write strobe is gated by that window;
- at most one plane is written per cycle;
- stored words stay stable without a write;
- an output with no reachable terms stays at 0.

The literal encoding, term sharing across outputs, the bank limits in fixed-bank mode, and the four-function example are all matters of truth-table values. Only the bench scenarios can show those, by sweeping the inputs after each configuration.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrAnd;   // store word into AND plane
    logic wrOr;    // store word into OR plane
    logic blank;   // force outputs to zero
  } cfg_strobe_t;
endpackage

// File: rtl/sop_array_ctrl.sv
module sop_array_ctrl
  import sop_array_pkg::*;
#(
  parameter int NUM_TERMS = 16,
  parameter int TERM_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgLoad,
  input  logic              cfgWrEn,
  input  logic              cfgPlane,
  input  logic [TERM_W-1:0] cfgTerm,
  output cfg_strobe_t       strobe
);
  logic termOk;
  logic wrOk;

  assign termOk = (32'(cfgTerm) < NUM_TERMS);
  assign wrOk   = cfgLoad && cfgWrEn && termOk;

  always_comb begin
    strobe       = '0;
    strobe.blank = cfgLoad;
    strobe.wrAnd = wrOk && !cfgPlane;
    strobe.wrOr  = wrOk && cfgPlane;
  end

  // R7: no write reaches the planes outside the load window
  assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !cfgLoad |-> !(strobe.wrAnd || strobe.wrOr));

  // R6: a write touches a single plane
  assert_one_plane_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrAnd, strobe.wrOr}));

  // R8: the blanking strobe follows the load window
  assert_blank_follows_R8: assert property (@(posedge clk) disable iff (rst)
    cfgLoad |-> strobe.blank);
endmodule

// File: rtl/sop_array_dp.sv
module sop_array_dp
  import sop_array_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_OUT   = 4,
  parameter int NUM_TERMS = 16,
  parameter int PAL_BANK  = 4,
  parameter int TERM_W    = 4,
  parameter int DATA_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               palMode,
  input  cfg_strobe_t        strobe,
  input  logic [TERM_W-1:0]  cfgTerm,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_IN-1:0]  inVec,
  output logic [NUM_OUT-1:0] funcOut
);
  localparam int AND_W = 2 * NUM_IN;

  logic [NUM_TERMS-1:0][AND_W-1:0]   andMem;
  logic [NUM_TERMS-1:0][NUM_OUT-1:0] orMem;
  logic [NUM_TERMS-1:0]              termHit;
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] conn;
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] reach;
  logic [NUM_OUT-1:0][NUM_TERMS-1:0] bankOnly;
  logic [NUM_OUT-1:0]                outRaw;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      andMem <= '0;
      orMem  <= '0;
    end else begin
      if (strobe.wrAnd) andMem[cfgTerm] <= cfgData[AND_W-1:0];
      if (strobe.wrOr)  orMem[cfgTerm]  <= cfgData[NUM_OUT-1:0];
    end
  end

  // AND plane
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [NUM_IN-1:0] litOk;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      logic needTrue;
      logic needFalse;
      assign needTrue  = andMem[t][2*i+1];
      assign needFalse = andMem[t][2*i];
      assign litOk[i]  = !(needTrue && !inVec[i]) && !(needFalse && inVec[i]);
    end
    assign termHit[t] = &litOk;
  end

  // OR plane with optional fixed banks
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_conn
      assign conn[o][t] = orMem[t][o];
      if ((t / PAL_BANK) == o) begin : g_own
        assign bankOnly[o][t] = 1'b1;
        assign reach[o][t]    = 1'b1;
      end else begin : g_other
        assign bankOnly[o][t] = 1'b0;
        assign reach[o][t]    = !palMode;
      end
    end
    assign outRaw[o] = |(termHit & conn[o] & reach[o]);

    // R4: no connected term means a zero output
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (conn[o] == '0) |-> !funcOut[o]);

    // R9: in bank mode, connections outside the own bank cannot drive
    assert_bank_confine_R9: assert property (@(posedge clk) disable iff (rst)
      (palMode && ((conn[o] & bankOnly[o]) == '0)) |-> !funcOut[o]);
  end

  assign funcOut = strobe.blank ? '0 : outRaw;

  // R8: blanked during configuration
  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.blank |-> (funcOut == '0));

  // R7: storage holds without a write strobe
  assert_and_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrAnd |=> $stable(andMem));
  assert_or_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrOr |=> $stable(orMem));
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_OUT   = 4,
  parameter int NUM_TERMS = 16,
  parameter int PAL_BANK  = 4,
  parameter int TERM_W    = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1,
  parameter int DATA_W    = (2 * NUM_IN > NUM_OUT) ? 2 * NUM_IN : NUM_OUT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               palMode,
  input  logic               cfgLoad,
  input  logic               cfgWrEn,
  input  logic               cfgPlane,
  input  logic [TERM_W-1:0]  cfgTerm,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_IN-1:0]  inVec,
  output logic [NUM_OUT-1:0] funcOut
);
  cfg_strobe_t strobe;

  sop_array_ctrl #(
    .NUM_TERMS(NUM_TERMS),
    .TERM_W   (TERM_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgLoad (cfgLoad),
    .cfgWrEn (cfgWrEn),
    .cfgPlane(cfgPlane),
    .cfgTerm (cfgTerm),
    .strobe  (strobe)
  );

  sop_array_dp #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .NUM_TERMS(NUM_TERMS),
    .PAL_BANK (PAL_BANK),
    .TERM_W   (TERM_W),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .palMode(palMode),
    .strobe (strobe),
    .cfgTerm(cfgTerm),
    .cfgData(cfgData),
    .inVec  (inVec),
    .funcOut(funcOut)
  );
endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       palMode = 1'b0;
  logic       cfgLoad = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic       cfgPlane = 1'b0;
  logic [3:0] cfgTerm = '0;
  logic [5:0] cfgData = '0;
  logic [2:0] inVec = '0;
  logic [3:0] funcOut;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  sop_array u_dut (
    .clk(clk), .rst(rst), .palMode(palMode), .cfgLoad(cfgLoad),
    .cfgWrEn(cfgWrEn), .cfgPlane(cfgPlane), .cfgTerm(cfgTerm),
    .cfgData(cfgData), .inVec(inVec), .funcOut(funcOut)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cfgLoad = 1'b0; cfgWrEn = 1'b0; palMode = 1'b0; inVec = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one-cycle strobe; value captured on the following rising edge
  task automatic wr(input int term, input logic plane, input logic [5:0] data);
    @(negedge clk);
    cfgTerm = 4'(term); cfgPlane = plane; cfgData = data; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic openLoad();
    @(negedge clk); cfgLoad = 1'b1;
  endtask
  task automatic closeLoad();
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic applyIn(input logic [2:0] v);
    inVec = v; #1;
  endtask

  // R1: reset state
  task automatic testReset();
    doReset();
    for (int v = 0; v < 8; v++) begin
      applyIn(3'(v));
      chk("R1 reset outputs", funcOut, 4'b0000);
    end
  endtask

  // R10, R5, R11, R8: shared-term example
  task automatic testExample();
    logic a, b, c;
    logic [3:0] exp;
    doReset();
    openLoad();
    wr(0, 1'b0, 6'b000010);  // A
    wr(1, 1'b0, 6'b010100);  // B'C'
    wr(2, 1'b0, 6'b010010);  // AC'
    wr(3, 1'b0, 6'b001010);  // AB
    wr(4, 1'b0, 6'b100100);  // B'C
    wr(0, 1'b1, 6'b001001);
    wr(1, 1'b1, 6'b000101);
    wr(2, 1'b1, 6'b000010);
    wr(3, 1'b1, 6'b000110);
    wr(4, 1'b1, 6'b001000);
    applyIn(3'b001);
    chk("R8 blanked in load window", funcOut, 4'b0000);
    closeLoad();
    #1;
    for (int v = 0; v < 8; v++) begin
      a = v[0]; b = v[1]; c = v[2];
      exp[0] = a | (!b & !c);
      exp[1] = (a & !c) | (a & b);
      exp[2] = (!b & !c) | (a & b);
      exp[3] = (!b & c) | a;
      applyIn(3'(v));  // no clock edge between input change and sample (R11)
      chk("R10 R5 R11 example functions", funcOut, exp);
    end
    openLoad();
    applyIn(3'b111);
    chk("R8 blanked after reopening", funcOut, 4'b0000);
    closeLoad();
  endtask

  // R3, R4, R2: literal encoding corners
  task automatic testLiterals();
    doReset();
    openLoad();
    wr(0, 1'b1, 6'b000001);  // term 0 all don't-care -> output 0
    closeLoad();
    #1;
    for (int v = 0; v < 8; v += 3) begin
      applyIn(3'(v));
      chk("R3 all don't-care term true; R4 empty outputs zero", funcOut, 4'b0001);
    end
    openLoad();
    wr(0, 1'b0, 6'b000011);  // literal 0 coded 11 -> constant false
    closeLoad();
    #1;
    for (int v = 0; v < 8; v++) begin
      applyIn(3'(v));
      chk("R2 code 11 constant false", funcOut, 4'b0000);
    end
    openLoad();
    wr(0, 1'b0, 6'b010000);  // C complemented only
    closeLoad();
    #1;
    applyIn(3'b011);
    chk("R2 complemented literal met", funcOut, 4'b0001);
    applyIn(3'b100);
    chk("R2 complemented literal missed", funcOut, 4'b0000);
  endtask

  // R7: writes outside the load window
  task automatic testIgnore();
    doReset();
    wr(0, 1'b1, 6'b001111);
    #1;
    applyIn(3'b101);
    chk("R7 write outside window ignored", funcOut, 4'b0000);
    openLoad();
    wr(6, 1'b1, 6'b000100);
    closeLoad();
    wr(6, 1'b1, 6'b000000);  // must not clear it
    #1;
    chk("R7 R6 stored word survives idle write", funcOut, 4'b0100);
  endtask

  // R9: fixed-bank mode
  task automatic testBanks();
    doReset();
    openLoad();
    wr(5, 1'b0, 6'b000010);  // A, in bank of output 1
    wr(5, 1'b1, 6'b000011);  // to outputs 0 and 1
    wr(12, 1'b1, 6'b001000); // constant true, bank of output 3
    closeLoad();
    palMode = 1'b0;
    applyIn(3'b001);
    chk("R9 shared mode A=1", funcOut, 4'b1011);
    applyIn(3'b000);
    chk("R9 shared mode A=0", funcOut, 4'b1000);
    palMode = 1'b1;
    applyIn(3'b001);
    chk("R9 bank mode drops foreign bit", funcOut, 4'b1010);
    applyIn(3'b000);
    chk("R9 bank mode A=0", funcOut, 4'b1000);
  endtask

  initial begin
    testReset();
    testExample();
    testLiterals();
    testIgnore();
    testBanks();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule